// File: doc/BRIEF.md
# Indirect Statistics Counter Bank

This block keeps the per-port traffic statistics of a 10/100 Ethernet MAC. The receive and transmit paths each drive a vector of one-cycle event strobes, one strobe per counter, together with the octet count of the frame that the event describes. Each strobe advances its own 32-bit counter. Among these counters are the frame-size histogram bins, the oversize counters, the jumbo counters and the octet totals. The frame classification that chooses which strobe fires is done upstream and is not part of this block.

Software never sees the counters directly. It writes one command word that holds a counter index and a read flag and/or a clear flag. The block raises a busy flag for one cycle and then does the operation. It then leaves the result in a data register and drops busy. A separate clear-all strobe zeroes the whole bank in one cycle.

Top module: `stat_counter_bank`

## Requirements
- R1: Receive strobe bit i (i = 0..26) advances the counter at index i. Transmit strobe bit j (j = 0..23) advances the counter at index 0x20+j. The receive size bins are indices 0x0E..0x13 (64, 65-127, 128-255, 256-511, 512-1023, 1024-1518 octets), receive oversize is 0x05 and receive jumbo is 0x1A. The transmit size bins are 0x30..0x35, transmit oversize is 0x36 and transmit jumbo is 0x37.
- R2: When their strobe fires, the octet counters at 0x01 and 0x0B add the receive octet count and the counter at 0x21 adds the transmit octet count. Every other counter adds exactly 1, whatever the octet count is.
- R3: Counters are 32 bits wide and wrap to zero on overflow.
- R4: In the command word, bit 13 requests a read, bit 12 requests a clear and bits 5:0 select the index. The status word returns bit 15 = busy, bits 13 and 12 as written, and bits 5:0 as written. A command written while the block is idle shows busy in the next cycle.
- R5: Busy stays high for exactly one cycle. When it falls, the data register holds the result, two clock edges after the command write.
- R6: A read of an index that has no counter (0x1B..0x1F, 0x38..0x3F) returns 0.
- R7: A clear command sets the selected counter to 0. A command without the read bit loads 0 into the data register. A command with both bits returns the value from before the clear and leaves the counter at 0.
- R8: An increment that arrives in the same cycle as a clear of that counter, whether from a command or from clear-all, leaves the counter at 0.
- R9: A command written while busy is high is ignored.
- R10: The clear-all strobe sets every counter to 0 in one cycle.
- R11: After reset the status word is 0, the data register is 0 and every counter reads 0.
- R12: The data register keeps its value until the next command completes, even while events keep arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_evt | input | 27 | Receive event strobes, bit i for index i |
| rx_octets | input | 16 | Octet count for receive octet counters |
| tx_evt | input | 24 | Transmit event strobes, bit j for index 0x20+j |
| tx_octets | input | 16 | Octet count for the transmit octet counter |
| clr_all | input | 1 | Zero every counter |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command word |
| stat_word | output | 16 | Busy flag and echo of the current command |
| rd_data | output | 32 | Result of the last completed command |

## Verification
Counter state cannot be seen at the ports until a command reads it. A wrong increment, a wrong octet weight, a missed clear or a lost wrap therefore shows up as a wrong value on rd_data when busy next falls, two edges after that read is written. Each check drives a known number of strobes and then reads the counter back, so the error is caught on that read. A fault in the command sequencing, such as busy lasting too long, a command accepted while busy, or data changing outside a completion, appears on stat_word or rd_data within one cycle.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

    localparam int STAT_CNT_W   = 32;
    localparam int STAT_OCT_W   = 16;
    localparam int STAT_CMD_W   = 16;
    localparam int IDX_W        = 6;
    localparam int RX_CNT_N     = 27;
    localparam int TX_CNT_N     = 24;
    localparam int TX_BASE      = 32;

    // command word fields
    localparam int BUSY_BIT     = 15;
    localparam int RD_BIT       = 13;
    localparam int CLR_BIT      = 12;

    // counters weighted by the octet count
    localparam int RX_OCT_IDX   = 1;
    localparam int RX_GOOD_IDX  = 11;
    localparam int TX_OCT_IDX   = 33;

    typedef struct packed {
        logic             busy;
        logic             rd;
        logic             clr;
        logic [IDX_W-1:0] idx;
    } cmd_t;

endpackage

// File: rtl/stat_cnt_bank.sv
module stat_cnt_bank
    import stat_bank_pkg::*;
#(
    parameter int              N        = RX_CNT_N,
    parameter int              BASE     = 0,
    parameter int              CNT_W    = STAT_CNT_W,
    parameter int              OCT_W    = STAT_OCT_W,
    parameter logic [N-1:0]    OCT_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     evt,
    input  logic [OCT_W-1:0] octets,
    input  logic             clr_all,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] sel_idx,
    output logic [CNT_W-1:0] sel_val
);

    localparam int PAD_W = CNT_W - OCT_W;

    logic [CNT_W-1:0] cnt_d [N];
    logic [CNT_W-1:0] cnt_q [N];
    logic [CNT_W-1:0] oct_amt;

    assign oct_amt = {{PAD_W{1'b0}}, octets};

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cnt_d[i] = cnt_q[i];
            if (evt[i]) begin
                cnt_d[i] = cnt_q[i] + (OCT_MASK[i] ? oct_amt : CNT_W'(1));
            end
            if (clr_all || (clr_en && sel_idx == IDX_W'(BASE + i))) begin
                cnt_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) cnt_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) cnt_q[i] <= cnt_d[i];
        end
    end

    // selected counter, zero when the index is outside this bank
    always_comb begin
        sel_val = '0;
        for (int i = 0; i < N; i++) begin
            if (sel_idx == IDX_W'(BASE + i)) sel_val = cnt_q[i];
        end
    end

endmodule

// File: rtl/stat_cmd_ctrl.sv
module stat_cmd_ctrl
    import stat_bank_pkg::*;
#(
    parameter int CNT_W = STAT_CNT_W,
    parameter int CMD_W = STAT_CMD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic [CNT_W-1:0] sel_val,
    output logic [IDX_W-1:0] sel_idx,
    output logic             clr_en,
    output logic [CMD_W-1:0] stat_word,
    output logic [CNT_W-1:0] rd_data
);

    localparam logic [CMD_W-1:0] USED_MASK =
        CMD_W'((1 << RD_BIT) | (1 << CLR_BIT) | ((1 << IDX_W) - 1));

    typedef struct packed {
        cmd_t             cmd;
        logic [CNT_W-1:0] data;
    } ctl_t;

    ctl_t st_d, st_q;
    logic unused_wbits;

    assign unused_wbits = ^(cmd_wdata & ~USED_MASK);

    always_comb begin
        st_d = st_q;
        if (st_q.cmd.busy) begin
            // completion: result lands as busy falls
            st_d.cmd.busy = 1'b0;
            st_d.data     = st_q.cmd.rd ? sel_val : '0;
        end else if (cmd_we) begin
            st_d.cmd.busy = 1'b1;
            st_d.cmd.rd   = cmd_wdata[RD_BIT];
            st_d.cmd.clr  = cmd_wdata[CLR_BIT];
            st_d.cmd.idx  = cmd_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_idx = st_q.cmd.idx;
    assign clr_en  = st_q.cmd.busy & st_q.cmd.clr;
    assign rd_data = st_q.data;

    always_comb begin
        stat_word               = '0;
        stat_word[BUSY_BIT]     = st_q.cmd.busy;
        stat_word[RD_BIT]       = st_q.cmd.rd;
        stat_word[CLR_BIT]      = st_q.cmd.clr;
        stat_word[IDX_W-1:0]    = st_q.cmd.idx;
    end

endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
    import stat_bank_pkg::*;
#(
    parameter int CNT_W = STAT_CNT_W,
    parameter int OCT_W = STAT_OCT_W,
    parameter int CMD_W = STAT_CMD_W,
    parameter int N_RX  = RX_CNT_N,
    parameter int N_TX  = TX_CNT_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_RX-1:0]  rx_evt,
    input  logic [OCT_W-1:0] rx_octets,
    input  logic [N_TX-1:0]  tx_evt,
    input  logic [OCT_W-1:0] tx_octets,
    input  logic             clr_all,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic [CMD_W-1:0] stat_word,
    output logic [CNT_W-1:0] rd_data
);

    localparam logic [N_RX-1:0] RX_OCT = N_RX'((1 << RX_OCT_IDX) | (1 << RX_GOOD_IDX));
    localparam logic [N_TX-1:0] TX_OCT = N_TX'(1 << (TX_OCT_IDX - TX_BASE));

    logic [IDX_W-1:0] sel_idx;
    logic             clr_en;
    logic [CNT_W-1:0] rx_val, tx_val, sel_val;

    stat_cnt_bank #(
        .N(N_RX), .BASE(0), .CNT_W(CNT_W), .OCT_W(OCT_W), .OCT_MASK(RX_OCT)
    ) rx_bank_i (
        .clk(clk), .rst_n(rst_n), .evt(rx_evt), .octets(rx_octets),
        .clr_all(clr_all), .clr_en(clr_en), .sel_idx(sel_idx), .sel_val(rx_val)
    );

    stat_cnt_bank #(
        .N(N_TX), .BASE(TX_BASE), .CNT_W(CNT_W), .OCT_W(OCT_W), .OCT_MASK(TX_OCT)
    ) tx_bank_i (
        .clk(clk), .rst_n(rst_n), .evt(tx_evt), .octets(tx_octets),
        .clr_all(clr_all), .clr_en(clr_en), .sel_idx(sel_idx), .sel_val(tx_val)
    );

    // the index ranges are disjoint, so at most one bank returns non-zero
    assign sel_val = rx_val | tx_val;

    stat_cmd_ctrl #(.CNT_W(CNT_W), .CMD_W(CMD_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .sel_val(sel_val), .sel_idx(sel_idx), .clr_en(clr_en),
        .stat_word(stat_word), .rd_data(rd_data)
    );

endmodule

// File: rtl/stat_counter_bank_chk.sv
module stat_counter_bank_chk
    import stat_bank_pkg::*;
#(
    parameter int CNT_W = STAT_CNT_W,
    parameter int CMD_W = STAT_CMD_W,
    parameter int N_RX  = RX_CNT_N,
    parameter int N_TX  = TX_CNT_N
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [CMD_W-1:0] stat_word,
    input logic [CNT_W-1:0] rd_data
);

    logic busy, rd_req, unmapped;
    int   idx;

    assign busy     = stat_word[BUSY_BIT];
    assign rd_req   = stat_word[RD_BIT];
    assign idx      = int'(stat_word[IDX_W-1:0]);
    assign unmapped = (idx >= N_RX && idx < TX_BASE) || (idx >= TX_BASE + N_TX);

    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy) |=> busy);

    p_busy_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_req && unmapped) |=> (rd_data == '0));

    p_clear_only_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_req) |=> (rd_data == '0));

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(stat_word[CMD_W-2:0]));

    p_data_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rd_data));

endmodule

bind stat_counter_bank stat_counter_bank_chk #(
    .CNT_W(CNT_W), .CMD_W(CMD_W), .N_RX(N_RX), .N_TX(N_TX)
) chk_i (.*);

// File: tb/stat_counter_bank_tb_top.sv
module stat_counter_bank_tb_top;
    import stat_bank_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [5:0]  idx;
        logic [7:0]  reps;
        logic [15:0] oct;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{6'h00, 8'd3, 16'd64,   32'd3},
        '{6'h01, 8'd4, 16'd100,  32'd400},
        '{6'h0B, 8'd2, 16'd1518, 32'd3036},
        '{6'h0E, 8'd5, 16'd64,   32'd5},
        '{6'h13, 8'd1, 16'd1518, 32'd1},
        '{6'h1A, 8'd7, 16'd9000, 32'd7},
        '{6'h21, 8'd3, 16'd256,  32'd768},
        '{6'h30, 8'd2, 16'd64,   32'd2},
        '{6'h37, 8'd6, 16'd9000, 32'd6},
        '{6'h1C, 8'd4, 16'd64,   32'd0},
        '{6'h3F, 8'd1, 16'd64,   32'd0}
    };

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [RX_CNT_N-1:0]   rx_evt;
    logic [TX_CNT_N-1:0]   tx_evt;
    logic [STAT_OCT_W-1:0] rx_octets, tx_octets;
    logic                  clr_all, cmd_we;
    logic [STAT_CMD_W-1:0] cmd_wdata;
    logic [STAT_CMD_W-1:0] stat_word;
    logic [STAT_CNT_W-1:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stat_counter_bank dut_i (
        .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .rx_octets(rx_octets),
        .tx_evt(tx_evt), .tx_octets(tx_octets), .clr_all(clr_all),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .stat_word(stat_word),
        .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] idx);
        if (idx == 6'h01 || idx == 6'h0B || idx == 6'h21) return "R2";
        if ((idx > 6'h1A && idx < 6'h20) || idx > 6'h37)   return "R6";
        return "R1";
    endfunction

    task automatic set_evt(input logic [5:0] idx, input logic v);
        if (idx < 6'd27)                     rx_evt[idx] = v;
        else if (idx >= 6'd32 && idx < 6'd56) tx_evt[idx - 6'd32] = v;
    endtask

    task automatic drive(input logic [5:0] idx, input int reps, input logic [15:0] oct);
        @(negedge clk);
        rx_octets = oct;
        tx_octets = oct;
        set_evt(idx, 1'b1);
        repeat (reps) @(negedge clk);
        set_evt(idx, 1'b0);
    endtask

    task automatic pulse_clr_all();
        @(negedge clk);
        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
    endtask

    task automatic issue(input logic [15:0] w, input string tag, output logic [31:0] data);
        @(negedge clk);
        cmd_we    = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
        check({tag, " R4 busy set"}, 32'(stat_word[15]), 32'd1);
        @(negedge clk);
        check({tag, " R5 busy clear"}, 32'(stat_word[15]), 32'd0);
        data = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; rx_evt = '0; tx_evt = '0; rx_octets = '0; tx_octets = '0;
        clr_all = 1'b0; cmd_we = 1'b0; cmd_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11 status", 32'(stat_word), 32'd0);
        check("R11 data", rd_data, 32'd0);
        issue(16'h2005, "R11", v);
        check("R11 counter", v, 32'd0);

        // table walk: R1, R2, R6
        for (int k = 0; k < NV; k++) begin
            pulse_clr_all();
            drive(VECS[k].idx, int'(VECS[k].reps), VECS[k].oct);
            issue(16'h2000 | 16'(VECS[k].idx), tag_of(VECS[k].idx), v);
            check(tag_of(VECS[k].idx), v, VECS[k].exp);
        end

        // R3: wrap of an octet counter
        pulse_clr_all();
        drive(6'h01, 65537, 16'hFFFF);
        issue(16'h2001, "R3", v);
        check("R3 full", v, 32'hFFFF_FFFF);
        drive(6'h01, 3, 16'd1);
        issue(16'h2001, "R3", v);
        check("R3 wrap", v, 32'd2);

        // R7: clear only, then read+clear
        drive(6'h22, 5, 16'd0);
        issue(16'h1022, "R7", v);
        check("R7 clear-only data", v, 32'd0);
        issue(16'h2022, "R7", v);
        check("R7 cleared", v, 32'd0);
        drive(6'h23, 4, 16'd0);
        issue(16'h3023, "R7", v);
        check("R7 read+clear value", v, 32'd4);
        issue(16'h2023, "R7", v);
        check("R7 after read+clear", v, 32'd0);

        // R8: increment in the completion cycle of a clear
        drive(6'h25, 2, 16'd0);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = 16'h1025;
        @(negedge clk);
        cmd_we = 1'b0; tx_evt[5] = 1'b1;
        @(negedge clk);
        tx_evt[5] = 1'b0;
        issue(16'h2025, "R8", v);
        check("R8 clear wins", v, 32'd0);

        // R10 and R8: clear-all with a coincident event
        drive(6'h30, 3, 16'd0);
        drive(6'h02, 2, 16'd0);
        @(negedge clk);
        clr_all = 1'b1; rx_evt[2] = 1'b1;
        @(negedge clk);
        clr_all = 1'b0; rx_evt[2] = 1'b0;
        issue(16'h2030, "R10", v);
        check("R10 other counter", v, 32'd0);
        issue(16'h2002, "R8", v);
        check("R8 clear-all wins", v, 32'd0);

        // R9: second write while busy is ignored; R4 status word
        drive(6'h04, 3, 16'd0);
        drive(6'h06, 1, 16'd0);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = 16'h2004;
        @(negedge clk);
        cmd_wdata = 16'h2006;
        check("R4 status word", 32'(stat_word), 32'h0000_A004);
        @(negedge clk);
        cmd_we = 1'b0;
        check("R9 data of first", rd_data, 32'd3);
        check("R9 index kept", 32'(stat_word), 32'h0000_2004);
        @(negedge clk);
        check("R9 no second busy", 32'(stat_word[15]), 32'd0);

        // R12: data register holds while events continue
        drive(6'h04, 5, 16'd0);
        @(negedge clk);
        check("R12 data held", rd_data, 32'd3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule